// File: doc/BRIEF.md
# Split-Mode Signed/Unsigned Multiplier Slice

This block is a multiplier slice that runs either as one 18x18 multiplier or as two independent 9x9 multipliers. The choice is made on every operand by a mode input. Each operand has its own sign-select bit. When the bit is set, that operand is read as two's complement. When it is clear, the operand is read as unsigned. A mixed pair gives the exact product of a signed value and an unsigned value. The same bit pattern therefore gives different results. For example, all-ones times all-ones is a large positive number when both operands are unsigned, and is +1 when both are signed.

The operand stage and the result stage can each be left out through a parameter, so the slice works as a combinational multiplier or as a pipelined one. The mode and sign bits are captured together with the operands. Each product is therefore computed in the mode that was presented with it, even when the mode changes on every cycle. A common clock enable freezes the whole slice. A separate result-load enable holds only the result register.

Top module: `split_mult18`

## Requirements
- R1: With `split_mode`=0 and both sign bits clear, `prod` is the exact 36-bit unsigned product of `op_a` and `op_b` (for example 3FFFF x 3FFFF = FFFF80001 hex, F x F = E1 hex).
- R2: With `split_mode`=0, `a_is_signed`=1 reads `op_a` as 18-bit two's complement and `b_is_signed`=1 does the same for `op_b`; `prod` is the exact product as a 36-bit two's-complement value (3FFFF x 3FFFF with both signed is 1; 3FFFF signed x 5 unsigned is FFFFFFFFB hex).
- R3: With `split_mode`=1, `prod[17:0]` is the product of `op_a[8:0]` and `op_b[8:0]`, and `prod[35:18]` is the product of `op_a[17:9]` and `op_b[17:9]`. No carry or sign passes between the halves.
- R4: In split mode each sign bit applies to both 9-bit halves of its operand, with sign extension from bit 8 and bit 17 respectively. Each 18-bit half-result is an exact two's-complement product.
- R5: With both stages registered, a result appears on `prod` after the second rising edge at which `clk_en` is high following the operand presentation. The mode and sign bits travel with their operands.
- R6: While `clk_en` is low, neither the operand register nor the result register changes, whatever the inputs do.
- R7: While `res_load` is low and `clk_en` is high, the operand register keeps capturing, the result register holds, and `prod` does not change.
- R8: Asserting `rst_n` low clears `prod` to zero at once, without waiting for a clock edge. After release, the slice resumes within two edges plus its pipeline latency.
- R9: With both stage parameters set to bypass, `prod` follows the current inputs combinationally, as defined in R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable for all registers |
| res_load | input | 1 | Load enable of the result register |
| split_mode | input | 1 | 0: one 18x18 product, 1: two 9x9 products |
| a_is_signed | input | 1 | Operand A is two's complement |
| b_is_signed | input | 1 | Operand B is two's complement |
| op_a | input | 18 | Operand A |
| op_b | input | 18 | Operand B |
| prod | output | 36 | Product, or two 18-bit products in split mode |

## Verification
The two functions that can fall in the same cycle are a change of mode or signedness and the completion of a product started under the old setting. In the registered slice, one product is in the result stage while the next operand, with a different mode, is being captured. The stimulus table alternates between full and split mode and between sign settings, and presents a new operand on every cycle. Each result is then judged two edges later against the value expected for its own mode and signs, so any mix-up between modes shows up as a wrong product.

// File: rtl/split_mult18_pkg.sv
`timescale 1ns/1ps
package split_mult18_pkg;
  localparam int OP_W   = 18;
  localparam int HALF_W = OP_W / 2;
  localparam int PROD_W = 2 * OP_W;
  localparam int HPROD_W = 2 * HALF_W;

  typedef struct packed {
    logic            split;
    logic            a_sgn;
    logic            b_sgn;
    logic [OP_W-1:0] a;
    logic [OP_W-1:0] b;
  } mul_req_t;
endpackage

// File: rtl/split_mult18_inreg.sv
`timescale 1ns/1ps
module split_mult18_inreg
  import split_mult18_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clk_en,
  input  mul_req_t req_d,
  output mul_req_t req_q
);
  generate
    if (REGISTERED) begin : g_reg
      mul_req_t hold_q, hold_nxt;

      always_comb begin
        hold_nxt = hold_q;
        if (clk_en) hold_nxt = req_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_nxt;
      end

      assign req_q = hold_q;

      // R6
      in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(hold_q));
    end else begin : g_bypass
      assign req_q = req_d;
    end
  endgenerate
endmodule

// File: rtl/split_mult18_core.sv
`timescale 1ns/1ps
module split_mult18_core
  import split_mult18_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mul_req_t          req,
  output logic [PROD_W-1:0] result
);
  logic signed [OP_W:0]     a_ext, b_ext;
  logic signed [PROD_W-1:0] full_p;
  logic [PROD_W-1:0]        split_p;

  assign a_ext  = $signed({req.a_sgn & req.a[OP_W-1], req.a});
  assign b_ext  = $signed({req.b_sgn & req.b[OP_W-1], req.b});
  assign full_p = PROD_W'(a_ext) * PROD_W'(b_ext);

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF_W-1:0]         a_h, b_h;
      logic signed [HALF_W:0]    a_hx, b_hx;
      logic signed [HPROD_W-1:0] p_h;

      assign a_h  = req.a[h*HALF_W +: HALF_W];
      assign b_h  = req.b[h*HALF_W +: HALF_W];
      assign a_hx = $signed({req.a_sgn & a_h[HALF_W-1], a_h});
      assign b_hx = $signed({req.b_sgn & b_h[HALF_W-1], b_h});
      assign p_h  = HPROD_W'(a_hx) * HPROD_W'(b_hx);
      assign split_p[h*HPROD_W +: HPROD_W] = p_h;
    end
  endgenerate

  assign result = req.split ? split_p : full_p;

  // R1
  full_unsigned_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req.split && !req.a_sgn && !req.b_sgn && req.b == OP_W'(1))
      |-> result == {{OP_W{1'b0}}, req.a});
  // R2
  full_signed_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req.split && req.a_sgn && !req.b_sgn && req.b == OP_W'(1))
      |-> result == {{OP_W{req.a[OP_W-1]}}, req.a});
  // R3
  split_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.split && req.a[HALF_W-1:0] == '0) |-> result[HPROD_W-1:0] == '0);
  // R4
  split_neg_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.split && req.a_sgn && req.b_sgn && (&req.a[HALF_W-1:0]) &&
     (&req.b[HALF_W-1:0])) |-> result[HPROD_W-1:0] == HPROD_W'(1));
endmodule

// File: rtl/split_mult18_outreg.sv
`timescale 1ns/1ps
module split_mult18_outreg
  import split_mult18_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PROD_W-1:0] res_d,
  output logic [PROD_W-1:0] res_q
);
  generate
    if (REGISTERED) begin : g_reg
      logic [PROD_W-1:0] p_q, p_nxt;

      always_comb begin
        p_nxt = p_q;
        if (load) p_nxt = res_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_nxt;
      end

      assign res_q = p_q;

      // R7
      out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(p_q));
      // R5
      out_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> p_q == $past(res_d));
    end else begin : g_bypass
      assign res_q = res_d;
    end
  endgenerate
endmodule

// File: rtl/split_mult18.sv
`timescale 1ns/1ps
module split_mult18
  import split_mult18_pkg::*;
#(
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              res_load,
  input  logic              split_mode,
  input  logic              a_is_signed,
  input  logic              b_is_signed,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] prod
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  mul_req_t          req_in, req_reg;
  logic [PROD_W-1:0] core_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1] & rst_n;

  assign req_in = '{split: split_mode, a_sgn: a_is_signed, b_sgn: b_is_signed,
                    a: op_a, b: op_b};

  split_mult18_inreg #(.REGISTERED(IN_REG)) u_in (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clk_en (clk_en),
    .req_d  (req_in),
    .req_q  (req_reg)
  );

  split_mult18_core u_core (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req    (req_reg),
    .result (core_res)
  );

  split_mult18_outreg #(.REGISTERED(OUT_REG)) u_out (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (clk_en & res_load),
    .res_d  (core_res),
    .res_q  (prod)
  );
endmodule

// File: tb/sim_split_mult18.sv
`timescale 1ns/1ps
module sim_split_mult18;
  localparam int N_VEC = 10;
  // {split, a_sgn, b_sgn, a[17:0], b[17:0], expected[35:0]}
  localparam logic [74:0] VEC [N_VEC] = '{
    {1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF, 36'hFFFF80001},
    {1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h3FFFF, 36'h000000001},
    {1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF, 36'hFF007FC01},
    {1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h00005, 36'hFFFFFFFFB},
    {1'b1, 1'b1, 1'b1, 18'h3FFFF, 18'h3FFFF, 36'h000040001},
    {1'b0, 1'b1, 1'b1, 18'h20000, 18'h20000, 36'h400000000},
    {1'b1, 1'b1, 1'b0, 18'h003FF, 18'h00803, 36'h00013FFFD},
    {1'b0, 1'b0, 1'b0, 18'h0000F, 18'h0000F, 36'h0000000E1},
    {1'b1, 1'b0, 1'b1, 18'h00405, 18'h3FDFF, 36'hFFFF3FFFB},
    {1'b0, 1'b0, 1'b0, 18'h00003, 18'h00007, 36'h000000015}
  };

  logic        clk = 1'b0;
  logic        rst_n, clk_en, res_load, split_mode, a_is_signed, b_is_signed;
  logic [17:0] op_a, op_b;
  logic [35:0] prod, prod_comb;
  int          n_total = 0;
  int          n_fail  = 0;

  always #2 clk = ~clk;

  split_mult18 u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .res_load(res_load),
    .split_mode(split_mode), .a_is_signed(a_is_signed),
    .b_is_signed(b_is_signed), .op_a(op_a), .op_b(op_b), .prod(prod)
  );

  split_mult18 #(.IN_REG(1'b0), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .res_load(res_load),
    .split_mode(split_mode), .a_is_signed(a_is_signed),
    .b_is_signed(b_is_signed), .op_a(op_a), .op_b(op_b), .prod(prod_comb)
  );

  task automatic chk(input string req, input logic [35:0] act,
                     input logic [35:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string vec_req(input logic [74:0] v);
    if (!v[74]) return (v[73] | v[72]) ? "R2" : "R1";
    return (v[73] | v[72]) ? "R4" : "R3";
  endfunction

  task automatic drive(input logic s, input logic sa, input logic sb,
                       input logic [17:0] a, input logic [17:0] b);
    split_mode = s; a_is_signed = sa; b_is_signed = sb; op_a = a; op_b = b;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    n_total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; res_load = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 18'h0, 18'h0);
    repeat (3) @(negedge clk);
    chk("R8 reset state", prod, 36'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table: a new operand every cycle, mode and signs change in flight
    for (int i = 0; i < N_VEC + 2; i++) begin
      @(negedge clk);
      if (i >= 2)
        chk({vec_req(VEC[i-2]), " R5 pipelined"}, prod, VEC[i-2][35:0]);
      if (i < N_VEC) begin
        drive(VEC[i][74], VEC[i][73], VEC[i][72], VEC[i][71:54], VEC[i][53:36]);
        #1;
        chk({vec_req(VEC[i]), " R9 bypass"}, prod_comb, VEC[i][35:0]);
      end
    end

    // R6: clock enable low freezes both stages
    clk_en = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 18'd1, 18'd2);
    repeat (3) @(negedge clk);
    chk("R6 hold under clk_en low", prod, 36'h15);
    clk_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 resume after clk_en", prod, 36'd2);

    // R7: result load low holds prod while operands advance
    res_load = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 18'd3, 18'd3);
    repeat (3) @(negedge clk);
    chk("R7 result held", prod, 36'd2);
    res_load = 1'b1;
    @(negedge clk);
    chk("R7 load of captured operand", prod, 36'd9);

    // R5: exact latency
    drive(1'b0, 1'b0, 1'b0, 18'd5, 18'd5);
    @(negedge clk);
    chk("R5 not yet after one edge", prod, 36'd9);
    @(negedge clk);
    chk("R5 product after two edges", prod, 36'd25);

    // R8: asynchronous clear mid-run, then recovery
    drive(1'b1, 1'b0, 1'b0, 18'h00605, 18'h00403);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear", prod, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // split: low 5*3=15, high 3*2=6
    chk("R8 R3 recovery split product", prod, {18'd6, 18'd15});

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule